// File: doc/BRIEF.md
# Channel Sample Source Selector

This block chooses the 16-bit sample that one converter channel sends on toward its serial interface. It can pass one of four external words: streamed memory data, looped-back receive data, a programmed constant, or a tone word from an outside generator. It can also send all zeros, or words from its own test generators. These are two pseudo-random sequences, each in true or inverted form, and a counting ramp.

A 4-bit select field chooses the source. Two override inputs can force loopback or the pseudo-random default code in its place. A sample-enable strobe loads the output register and steps every internal generator. Between strobes the output holds its value.

The asynchronous active-low reset input passes through a two-flop synchronizer before it reaches the core. The core therefore leaves reset two clock edges after the pin is released.

Top module: `chan_src_sel`

## Requirements
- R1: While the core is in reset, the output is 0x0000. The first strobe after reset returns the pseudo-random words generated from an all-ones seed and a ramp value of 0x0000.
- R2: The output register loads only on a clock edge where `smp_en` is high, so the result appears one cycle later. With `smp_en` low the output holds, whatever the other inputs do.
- R3: The effective code selects a pass-through word: 0x0 selects `tone_data`, 0x1 selects `patt_data`, 0x2 selects `dma_data` and 0x8 selects `adc_data`.
- R4: Effective code 0x3 gives 0x0000. The codes that have no source (0x9, 0xA and 0xC to 0xF) also give 0x0000.
- R5: Code 0x6 gives the short sequence from a 7-bit shift register with feedback x^7+x^6+1. Each strobe shifts the register 16 times. The new bit is state[6]^state[5] and is shifted in at the low end. The first bit of the 16 lands in bit 15 of the word.
- R6: Code 0x7 gives the long sequence, built the same way from a 15-bit register with feedback x^15+x^14+1 (new bit = state[14]^state[13]).
- R7: Code 0x4 gives the bitwise complement of the short sequence word, and code 0x5 gives the complement of the long sequence word.
- R8: Code 0xB gives a ramp that grows by one on each strobe and wraps from 0xFFFF to 0x0000.
- R9: Every strobe advances all generators, whatever code is selected.
- R10: When `ovr_lpbk` is 1 and `ovr_pn` is 0, the effective code is 0x8, so the output is `adc_data` whatever `sel_code` holds.
- R11: When `ovr_pn` is 1 and `ovr_lpbk` is 0, the effective code is 0x9, so the output is 0x0000.
- R12: When both override inputs are 1, both are ignored and `sel_code` is the effective code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample strobe: loads the output and steps the generators |
| sel_code | input | 4 | Programmed source code |
| ovr_lpbk | input | 1 | Forces loopback selection |
| ovr_pn | input | 1 | Forces the pseudo-random default code |
| dma_data | input | 16 | Streamed memory sample |
| adc_data | input | 16 | Loopback sample |
| tone_data | input | 16 | Sample from the external tone generator |
| patt_data | input | 16 | Programmed constant pattern |
| sample_out | output | 16 | Registered selected sample |

## Verification
The hardest state to reach from the ports is the ramp wrapping from 0xFFFF to 0x0000. It needs 65536 strobes after reset, so the bench holds code 0xB with a strobe on every cycle for just over one full period. It checks every word on the way.

The free-running behaviour of the generators is hidden whenever a pass-through code is selected. To expose it, the bench runs strobes on other codes first, then switches to a sequence code and compares against a model that stepped on every strobe.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int SAMPLE_W = 16;
  localparam int CODE_W   = 4;

  localparam logic [CODE_W-1:0] CODE_TONE   = 4'h0;
  localparam logic [CODE_W-1:0] CODE_PATT   = 4'h1;
  localparam logic [CODE_W-1:0] CODE_DMA    = 4'h2;
  localparam logic [CODE_W-1:0] CODE_ZERO   = 4'h3;
  localparam logic [CODE_W-1:0] CODE_NPN7   = 4'h4;
  localparam logic [CODE_W-1:0] CODE_NPN15  = 4'h5;
  localparam logic [CODE_W-1:0] CODE_PN7    = 4'h6;
  localparam logic [CODE_W-1:0] CODE_PN15   = 4'h7;
  localparam logic [CODE_W-1:0] CODE_LPBK   = 4'h8;
  localparam logic [CODE_W-1:0] CODE_PNDEV  = 4'h9;
  localparam logic [CODE_W-1:0] CODE_RAMP   = 4'hB;

  localparam int PN_SHORT_W = 7;
  localparam int PN_LONG_W  = 15;
endpackage

// File: rtl/csel_rst_sync.sv
module csel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/csel_pn_gen.sv
module csel_pn_gen #(
  parameter int STATE_W = 7,
  parameter int WORD_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  output logic [WORD_W-1:0]  word_o
);
  localparam int TAP_A = STATE_W - 1;
  localparam int TAP_B = STATE_W - 2;

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic [STATE_W-1:0] walk;
  logic [WORD_W-1:0]  word_c;

  always_comb begin
    walk   = state_q;
    word_c = '0;
    for (int i = 0; i < WORD_W; i++) begin
      word_c = {word_c[WORD_W-2:0], walk[TAP_A] ^ walk[TAP_B]};
      walk   = {walk[STATE_W-2:0], walk[TAP_A] ^ walk[TAP_B]};
    end
    state_d = adv ? walk : state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '1;
    else        state_q <= state_d;
  end

  assign word_o = word_c;
endmodule

// File: rtl/csel_ramp_gen.sv
module csel_ramp_gen #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] cnt_q;
  logic [WORD_W-1:0] cnt_d;

  always_comb cnt_d = adv ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign word_o = cnt_q;
endmodule

// File: rtl/csel_sel_resolve.sv
module csel_sel_resolve
  import csel_pkg::*;
(
  input  logic [CODE_W-1:0] sel_code,
  input  logic              ovr_lpbk,
  input  logic              ovr_pn,
  output logic [CODE_W-1:0] eff_code
);
  always_comb begin
    unique case ({ovr_lpbk, ovr_pn})
      2'b10:   eff_code = CODE_LPBK;
      2'b01:   eff_code = CODE_PNDEV;
      default: eff_code = sel_code;
    endcase
  end
endmodule

// File: rtl/chan_src_sel.sv
module chan_src_sel
  import csel_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_en,
  input  logic [CODE_W-1:0]   sel_code,
  input  logic                ovr_lpbk,
  input  logic                ovr_pn,
  input  logic [SAMPLE_W-1:0] dma_data,
  input  logic [SAMPLE_W-1:0] adc_data,
  input  logic [SAMPLE_W-1:0] tone_data,
  input  logic [SAMPLE_W-1:0] patt_data,
  output logic [SAMPLE_W-1:0] sample_out
);
  logic                rst_core_n;
  logic [CODE_W-1:0]   eff_code;
  logic [SAMPLE_W-1:0] pn_short;
  logic [SAMPLE_W-1:0] pn_long;
  logic [SAMPLE_W-1:0] ramp;
  logic [SAMPLE_W-1:0] mux_c;
  logic [SAMPLE_W-1:0] out_d;
  logic [SAMPLE_W-1:0] out_q;

  csel_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  csel_sel_resolve u_res (
    .sel_code(sel_code), .ovr_lpbk(ovr_lpbk), .ovr_pn(ovr_pn), .eff_code(eff_code)
  );

  csel_pn_gen #(.STATE_W(PN_SHORT_W), .WORD_W(SAMPLE_W)) u_pn_short (
    .clk(clk), .rst_n(rst_core_n), .adv(smp_en), .word_o(pn_short)
  );

  csel_pn_gen #(.STATE_W(PN_LONG_W), .WORD_W(SAMPLE_W)) u_pn_long (
    .clk(clk), .rst_n(rst_core_n), .adv(smp_en), .word_o(pn_long)
  );

  csel_ramp_gen #(.WORD_W(SAMPLE_W)) u_ramp (
    .clk(clk), .rst_n(rst_core_n), .adv(smp_en), .word_o(ramp)
  );

  always_comb begin
    unique case (eff_code)
      CODE_TONE:  mux_c = tone_data;
      CODE_PATT:  mux_c = patt_data;
      CODE_DMA:   mux_c = dma_data;
      CODE_NPN7:  mux_c = ~pn_short;
      CODE_NPN15: mux_c = ~pn_long;
      CODE_PN7:   mux_c = pn_short;
      CODE_PN15:  mux_c = pn_long;
      CODE_LPBK:  mux_c = adc_data;
      CODE_RAMP:  mux_c = ramp;
      default:    mux_c = '0;
    endcase
    out_d = smp_en ? mux_c : out_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) out_q <= '0;
    else             out_q <= out_d;
  end

  assign sample_out = out_q;
endmodule

// File: rtl/chan_src_sel_chk.sv
module chan_src_sel_chk (
  input logic        clk,
  input logic        core_rst_n,
  input logic        smp_en,
  input logic [3:0]  sel_code,
  input logic        ovr_lpbk,
  input logic        ovr_pn,
  input logic [15:0] dma_data,
  input logic [15:0] adc_data,
  input logic [15:0] sample_out
);
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!core_rst_n)
    !smp_en |=> $stable(sample_out)); // R2

  AST_DMA_PASS: assert property (@(posedge clk) disable iff (!core_rst_n)
    (smp_en && !ovr_lpbk && !ovr_pn && sel_code == 4'h2) |=> sample_out == $past(dma_data)); // R3

  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (smp_en && !ovr_lpbk && !ovr_pn && sel_code == 4'h3) |=> sample_out == 16'h0000); // R4

  AST_LPBK_FORCE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (smp_en && ovr_lpbk && !ovr_pn) |=> sample_out == $past(adc_data)); // R10

  AST_PN_FORCE_ZERO: assert property (@(posedge clk) disable iff (!core_rst_n)
    (smp_en && ovr_pn && !ovr_lpbk) |=> sample_out == 16'h0000); // R11

  AST_BOTH_CANCEL: assert property (@(posedge clk) disable iff (!core_rst_n)
    (smp_en && ovr_pn && ovr_lpbk && sel_code == 4'h2) |=> sample_out == $past(dma_data)); // R12
endmodule

bind chan_src_sel chan_src_sel_chk u_chk (
  .clk(clk), .core_rst_n(rst_core_n), .smp_en(smp_en), .sel_code(sel_code),
  .ovr_lpbk(ovr_lpbk), .ovr_pn(ovr_pn), .dma_data(dma_data),
  .adc_data(adc_data), .sample_out(sample_out)
);

// File: tb/chan_src_sel_bench.sv
`timescale 1ns/1ps
module chan_src_sel_bench;
  logic        clk;
  logic        rst_n;
  logic        smp_en;
  logic [3:0]  sel_code;
  logic        ovr_lpbk, ovr_pn;
  logic [15:0] dma_data, adc_data, tone_data, patt_data;
  logic [15:0] sample_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [6:0]  m_pn7;
  logic [14:0] m_pn15;
  logic [15:0] m_ramp;
  logic [15:0] m_last;

  chan_src_sel u_chan_src_sel (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .sel_code(sel_code),
    .ovr_lpbk(ovr_lpbk), .ovr_pn(ovr_pn), .dma_data(dma_data),
    .adc_data(adc_data), .tone_data(tone_data), .patt_data(patt_data),
    .sample_out(sample_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] short_word(input logic [6:0] s);
    logic [15:0] w = '0;
    logic [6:0]  t = s;
    for (int i = 0; i < 16; i++) begin
      w = {w[14:0], t[6] ^ t[5]};
      t = {t[5:0], t[6] ^ t[5]};
    end
    return w;
  endfunction

  function automatic logic [6:0] short_next(input logic [6:0] s);
    logic [6:0] t = s;
    for (int i = 0; i < 16; i++) t = {t[5:0], t[6] ^ t[5]};
    return t;
  endfunction

  function automatic logic [15:0] long_word(input logic [14:0] s);
    logic [15:0] w = '0;
    logic [14:0] t = s;
    for (int i = 0; i < 16; i++) begin
      w = {w[14:0], t[14] ^ t[13]};
      t = {t[13:0], t[14] ^ t[13]};
    end
    return w;
  endfunction

  function automatic logic [14:0] long_next(input logic [14:0] s);
    logic [14:0] t = s;
    for (int i = 0; i < 16; i++) t = {t[13:0], t[14] ^ t[13]};
    return t;
  endfunction

  function automatic logic [3:0] eff(input logic [3:0] c, input logic lb, input logic pn);
    if (lb && !pn) return 4'h8;
    if (pn && !lb) return 4'h9;
    return c;
  endfunction

  function automatic logic [15:0] model_out(input logic [3:0] c);
    case (c)
      4'h0: return tone_data;
      4'h1: return patt_data;
      4'h2: return dma_data;
      4'h4: return ~short_word(m_pn7);
      4'h5: return ~long_word(m_pn15);
      4'h6: return short_word(m_pn7);
      4'h7: return long_word(m_pn15);
      4'h8: return adc_data;
      4'hB: return m_ramp;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'h0, 4'h1, 4'h2, 4'h8: return "R3";
      4'h4, 4'h5: return "R7";
      4'h6: return "R5";
      4'h7: return "R6";
      4'hB: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic compare(input logic [15:0] exp, input string tag);
    checks++;
    if (sample_out !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", tag, sample_out, exp, $time);
    end
  endtask

  task automatic put_data(input int k);
    dma_data  = 16'hA5C3 ^ 16'(k * 37);
    adc_data  = 16'h3C5A ^ 16'(k * 91);
    tone_data = 16'h0F0F + 16'(k * 13);
    patt_data = 16'hBEEF - 16'(k * 7);
  endtask

  // Called at a negedge: drive, let one posedge pass, check at next negedge.
  task automatic apply(input logic [3:0] c, input logic lb, input logic pn,
                       input logic en, input string tag);
    logic [15:0] exp;
    sel_code = c; ovr_lpbk = lb; ovr_pn = pn; smp_en = en;
    exp = en ? model_out(eff(c, lb, pn)) : m_last;
    if (en) begin
      m_pn7  = short_next(m_pn7);
      m_pn15 = long_next(m_pn15);
      m_ramp = m_ramp + 16'd1;
    end
    @(negedge clk);
    m_last = exp;
    compare(exp, (tag == "") ? tag_of(eff(c, lb, pn)) : tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_en = 1'b0; sel_code = 4'h0; ovr_lpbk = 1'b0; ovr_pn = 1'b0;
    put_data(0);
    m_pn7 = '1; m_pn15 = '1; m_ramp = '0; m_last = '0;
    repeat (3) @(negedge clk);
    compare(16'h0000, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare(16'h0000, "R1");

    // R1: first strobe after reset shows seeded short sequence
    apply(4'h6, 1'b0, 1'b0, 1'b1, "R1");
    apply(4'h7, 1'b0, 1'b0, 1'b1, "R1");

    // Sweep every code, several data patterns, overrides off
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 16; c++) begin
        put_data(r * 16 + c + 1);
        apply(4'(c), 1'b0, 1'b0, 1'b1, "");
      end
    end

    // R2: no strobe, inputs wiggle, output holds
    for (int k = 0; k < 6; k++) begin
      put_data(200 + k);
      apply(4'(k * 3), k[0], k[1], 1'b0, "R2");
    end

    // R9: strobes on pass-through codes, then read generators
    for (int k = 0; k < 5; k++) begin
      put_data(300 + k);
      apply(4'h2, 1'b0, 1'b0, 1'b1, "R3");
    end
    apply(4'h6, 1'b0, 1'b0, 1'b1, "R9");
    apply(4'h5, 1'b0, 1'b0, 1'b1, "R9");

    // Overrides across all select codes
    for (int c = 0; c < 16; c++) begin
      put_data(400 + c);
      apply(4'(c), 1'b1, 1'b0, 1'b1, "R10");
      apply(4'(c), 1'b0, 1'b1, 1'b1, "R11");
      apply(4'(c), 1'b1, 1'b1, 1'b1, "R12");
    end

    // R8: ramp across a full wrap
    for (int k = 0; k < 65540; k++) apply(4'hB, 1'b0, 1'b0, 1'b1, "R8");
    apply(4'hB, 1'b0, 1'b0, 1'b0, "R2");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule